// File: doc/BRIEF.md
# Partial Output Isolation Ring

This block wraps the output side of an opaque core whose outputs feed downstream logic. Each core output belongs to one of two classes, chosen at build time through a bit mask. A ring position has a serial cell, a shadow (update) stage and a test multiplexer. In test mode the multiplexer lets a shifted-in value drive the downstream logic in place of the core. A capture-only position has just a serial cell hung off the wire. The wire runs from the core output to the downstream input untouched, so timing-critical paths carry no added gate.

During test, the downstream logic therefore sees a mixed vector. Ring positions carry values loaded through the scan chain. Capture-only positions carry whatever response the core itself is producing at that moment. Every position, of either class, is loaded into the serial chain on a capture strobe, so the whole core response can be shifted out and observed.

Top module: `out_ring_wrap`

## Requirements
- R1: After reset every serial cell and every shadow stage holds 0, so scan_out is 0 and, with test_mode high, every ring position of dn_in reads 0.
- R2: With test_mode low, dn_in equals core_out on every bit.
- R3: A capture-only position (RING_MASK bit 0) of dn_in always equals the same bit of core_out, whatever test_mode, the chain or the controls are doing.
- R4: With test_mode high, a ring position (RING_MASK bit 1) of dn_in shows its shadow stage, independent of core_out.
- R5: The serial order is fixed. scan_in feeds the ring cell of the lowest ring index. Ring cells follow in ascending core index, then capture-only cells in ascending core index. scan_out is the last cell. Each cycle with shift_en high moves the chain one place.
- R6: A cycle with capture_en high and shift_en low loads each cell with its own core output. At the next cycle scan_out shows the core output mapped to the last cell.
- R7: The shadow stages load from their ring cells only in a cycle with update_en high and shift_en low. Otherwise they hold, so ring positions of dn_in stay steady while the chain shifts.
- R8: shift_en takes priority: with shift_en high, capture_en and update_en have no effect.
- R9: With the default mask (indices 0, 1 and 4 in the ring), core_out bits 2 and 3 set to 1 and 0 yield dn_in bits 2 and 3 of 1 and 0 for every loaded ring value. The ring bits take the loaded values, so any vector of that form reaches the downstream logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_out | input | N_OUT | Core output bus |
| dn_in | output | N_OUT | Bus to the downstream logic inputs |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output |
| shift_en | input | 1 | Shift the chain one place |
| capture_en | input | 1 | Load the chain from core_out |
| update_en | input | 1 | Copy ring cells into shadow stages |
| test_mode | input | 1 | Select shadow values on ring positions |

## Verification
The dn_in and test-mode paths are combinational, so the bench checks them in the same half cycle it drives the inputs. Capture, shift and update act at the next rising edge. Stimulus is applied at the falling edge and results are read at the next falling edge, one register later. A shifted-out response is read bit by bit, one edge apart, in the serial order of R5. A loaded ring value appears on dn_in at the falling edge that follows its update edge.

// File: rtl/out_ring_wrap.sv
module out_ring_wrap #(
  parameter int N_OUT = 5,
  parameter logic [N_OUT-1:0] RING_MASK = 5'b10011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] dn_in,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             update_en,
  input  logic             test_mode
);

  function automatic int ring_count();
    int c = 0;
    for (int k = 0; k < N_OUT; k++) if (RING_MASK[k]) c++;
    return c;
  endfunction

  localparam int N_RING = ring_count();

  function automatic int chain_pos(int idx);
    int c = 0;
    for (int k = 0; k < idx; k++) if (RING_MASK[k] == RING_MASK[idx]) c++;
    return RING_MASK[idx] ? c : N_RING + c;
  endfunction

  logic [N_OUT-1:0] chain_q;
  logic [N_OUT-1:0] cap_vec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          chain_q <= '0;
    else if (shift_en)   chain_q <= {chain_q[N_OUT-2:0], scan_in};
    else if (capture_en) chain_q <= cap_vec;

  assign scan_out = chain_q[N_OUT-1];

  for (genvar i = 0; i < N_OUT; i++) begin : g_pos
    localparam int P = chain_pos(i);
    assign cap_vec[P] = core_out[i];
    if (RING_MASK[i]) begin : g_ring
      logic shadow_q;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                     shadow_q <= 1'b0;
        else if (update_en && !shift_en) shadow_q <= chain_q[P];
      assign dn_in[i] = test_mode ? shadow_q : core_out[i];
    end else begin : g_obs
      assign dn_in[i] = core_out[i];
    end
  end

endmodule

// File: rtl/out_ring_wrap_chk.sv
module out_ring_wrap_chk #(
  parameter int N_OUT = 5,
  parameter logic [N_OUT-1:0] RING_MASK = 5'b10011
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] core_out,
  input logic [N_OUT-1:0] dn_in,
  input logic             scan_out,
  input logic             shift_en,
  input logic             capture_en,
  input logic             update_en,
  input logic             test_mode
);

  function automatic int last_idx();
    int r = -1;
    for (int k = 0; k < N_OUT; k++) if (!RING_MASK[k]) r = k;
    if (r < 0) for (int k = 0; k < N_OUT; k++) r = k;
    return r;
  endfunction

  localparam int LAST = last_idx();

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> dn_in == core_out);

  a_r3_obs_live: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_in & ~RING_MASK) == (core_out & ~RING_MASK));

  a_r6_capture_tail: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(capture_en) && !$past(shift_en)) |-> scan_out == $past(core_out[LAST]));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (test_mode && $past(test_mode) && !($past(update_en) && !$past(shift_en)))
      |-> (dn_in & RING_MASK) == ($past(dn_in) & RING_MASK));

  a_r8_shift_wins: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (test_mode && $past(test_mode) && $past(shift_en))
      |-> (dn_in & RING_MASK) == ($past(dn_in) & RING_MASK));

endmodule

bind out_ring_wrap out_ring_wrap_chk #(.N_OUT(N_OUT), .RING_MASK(RING_MASK)) chk (
  .clk(clk), .rst_n(rst_n), .core_out(core_out), .dn_in(dn_in),
  .scan_out(scan_out), .shift_en(shift_en), .capture_en(capture_en),
  .update_en(update_en), .test_mode(test_mode)
);

// File: tb/out_ring_wrap_test.sv
module out_ring_wrap_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam logic [N-1:0] MASK = 5'b10011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] core_out = '0;
  logic [N-1:0] dn_in;
  logic scan_in = 1'b0, scan_out;
  logic shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, test_mode = 1'b0;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int order [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  out_ring_wrap #(.N_OUT(N), .RING_MASK(MASK)) uut (
    .clk(clk), .rst_n(rst_n), .core_out(core_out), .dn_in(dn_in),
    .scan_in(scan_in), .scan_out(scan_out), .shift_en(shift_en),
    .capture_en(capture_en), .update_en(update_en), .test_mode(test_mode)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load_ring(logic [2:0] v);
    logic [N-1:0] b;
    b = '0;
    for (int p = 0; p < 3; p++) b[N-1-p] = v[p];
    shift_en = 1'b1;
    for (int k = 0; k < N; k++) begin scan_in = b[k]; step(); end
    shift_en = 1'b0; scan_in = 1'b0; update_en = 1'b1;
    step();
    update_en = 1'b0;
  endtask

  function automatic logic [N-1:0] expect_dn(logic [2:0] v, logic [N-1:0] c);
    logic [N-1:0] r;
    r = c;
    for (int p = 0; p < 3; p++) r[order[p]] = v[p];
    return r;
  endfunction

  initial begin
    int q = 0;
    for (int i = 0; i < N; i++) if (MASK[i]) begin order[q] = i; q++; end
    for (int i = 0; i < N; i++) if (!MASK[i]) begin order[q] = i; q++; end

    step(); step();
    rst_n = 1'b1;
    step();
    check("R1 scan_out", scan_out, 0);
    test_mode = 1'b1; core_out = 5'b11111; #1;
    check("R1 ring zero", dn_in & MASK, 0);
    test_mode = 1'b0;

    for (int c = 0; c < 32; c++) begin
      core_out = c[N-1:0]; #1;
      check("R2 bypass", dn_in, c);
    end

    for (int c = 0; c < 32; c++) begin
      core_out = c[N-1:0]; capture_en = 1'b1;
      step();
      capture_en = 1'b0; core_out = ~c[N-1:0];
      check("R6 capture tail", scan_out, c[order[N-1]]);
      shift_en = 1'b1;
      for (int s = 1; s < N; s++) begin
        step();
        check("R5 order", scan_out, c[order[N-1-s]]);
      end
      shift_en = 1'b0;
    end

    test_mode = 1'b1;
    for (int v = 0; v < 8; v++) begin
      load_ring(v[2:0]);
      for (int c = 0; c < 32; c++) begin
        core_out = c[N-1:0]; #1;
        check("R4 R3 mix", dn_in, expect_dn(v[2:0], c[N-1:0]));
      end
      core_out = 5'b00100; #1;
      check("R9 XX10X", dn_in[3:2], 2'b01);
    end

    load_ring(3'b101);
    core_out = 5'b01010;
    shift_en = 1'b1;
    for (int k = 0; k < N; k++) begin
      scan_in = 1'b1; step();
      check("R7 hold while shifting", dn_in, expect_dn(3'b101, 5'b01010));
    end
    update_en = 1'b1; capture_en = 1'b1;
    step();
    check("R8 update ignored", dn_in, expect_dn(3'b101, 5'b01010));
    shift_en = 1'b0; capture_en = 1'b0; update_en = 1'b0; scan_in = 1'b0;
    check("R8 capture ignored", scan_out, 1);
    update_en = 1'b1;
    step();
    update_en = 1'b0;
    check("R7 update applies", dn_in, expect_dn(3'b111, 5'b01010));

    test_mode = 1'b0; #1;
    check("R2 bypass after load", dn_in, 5'b01010);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule